// File: doc/BRIEF.md
# Configurable Interrupt Aggregation Controller

The controller merges a set of internal event lines into a single host interrupt pin and a separate overflow pin. Every source passes through a two-flop synchronizer. A per-source trigger mode then qualifies it: on a rising edge, on a falling edge, or on its level. Edge-qualified events are latched in a sticky status bit. Level-qualified sources show their present synchronized level.

The interrupt pin asserts while any status bit is set and its mask bit is clear. One configuration bit picks the electrical behaviour of that pin: an active-high push-pull output, or an active-low open-drain output modelled as an output enable with the data held low. The overflow pin is an active-low open-drain output. It follows the OR of two chosen status bits (overflow and underflow), and no mask bit affects it.

A simple register port gives access to the configuration, mask and mode registers. Reading the status register clears its latched bits.

Top module: `irq_aggr_ctrl`

## Requirements
- R1: After reset the status reads 0x00, the mask reads all ones, the configuration and mode registers read 0x00, `irq_oe` is 1, `irq_o` is 0, `ovfl_oe` is 0 and `ovfl_o` is 0.
- R2: A source in rising mode (mode code 01) sets its status bit on a 0-to-1 change of the synchronized source. The bit stays set after the source returns to 0.
- R3: A source in falling mode (mode code 10) sets its status bit only on a 1-to-0 change. A 0-to-1 change leaves the bit clear.
- R4: A source in level mode (mode code 00 or 11) shows its synchronized level in its status bit. The bit is not sticky, and a status read does not clear it.
- R5: A read of the status register (address 0x0D) returns the current status and clears every latched edge bit at the end of that read cycle. If a new edge is qualified in the same cycle, the edge wins and the bit stays set.
- R6: The interrupt is pending only when at least one status bit is set while its mask bit (mask register bit i for source i, 1 = masked) is 0. A masked source alone never activates the pin.
- R7: With configuration bit 0 at 0, the pin is push-pull active high: `irq_oe` is 1 and `irq_o` equals the pending state.
- R8: With configuration bit 0 at 1, the pin is open-drain active low: `irq_o` is held at 0 and `irq_oe` equals the pending state.
- R9: `ovfl_o` is always 0. `ovfl_oe` is 1 exactly when the status bit of the overflow source (index 6) or the underflow source (index 7) is set, whatever the mask holds.
- R10: The register map is: configuration at 0x0 (only bit 0 is stored; the other bits read 0), mask at 0x1, mode at 0x4 for sources 0..3 and at 0x5 for sources 4..7 (source i uses bits 2(i mod 4)+1 : 2(i mod 4)), and status at 0x0D. The status register is read-only, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Asynchronous event sources |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid in the cycle the strobe is high |
| irq_o | output | 1 | Interrupt data |
| irq_oe | output | 1 | Interrupt output enable |
| ovfl_o | output | 1 | Overflow data, held at 0 |
| ovfl_oe | output | 1 | Overflow output enable, high to pull the line low |

## Verification
The bench builds the block with its defaults: eight sources, 8-bit data, and overflow and underflow on sources 6 and 7. With these values both mode registers are in use, so both address decodes are exercised, and both overflow inputs can be driven separately. Because the data width equals the source count, every status, mask and mode bit can be read back directly. The bench also places a read exactly in the cycle where a rising edge is qualified, to check that the set takes priority over the clear.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'h1;
  localparam logic [ADDR_W-1:0] A_MODE0 = 4'h4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'hD;

  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'b00,
    TRIG_RISE   = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_LEVEL2 = 2'b11
  } trig_e;

  function automatic logic trig_is_level(trig_e m);
    return (m == TRIG_LEVEL) || (m == TRIG_LEVEL2);
  endfunction

  function automatic logic trig_hit(trig_e m, logic cur, logic old);
    case (m)
      TRIG_RISE: return cur & ~old;
      TRIG_FALL: return ~cur & old;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_aggr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  src_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  sync_o,
  output logic  edge_o,
  output logic  sticky_o,
  output logic  stat_o
);
  logic meta_q, sync_q, prev_q, sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = trig_hit(mode_i, sync_q, prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    sticky_q <= 1'b0;
    else if (trig_is_level(mode_i)) sticky_q <= 1'b0;
    else if (edge_o)                sticky_q <= 1'b1;
    else if (clr_i)                 sticky_q <= 1'b0;
  end

  assign sync_o   = sync_q;
  assign sticky_o = sticky_q;
  assign stat_o   = trig_is_level(mode_i) ? sync_q : sticky_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_aggr_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [NUM_SRC-1:0]   status_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 cfg_od_o,
  output logic [NUM_SRC-1:0]   mask_o,
  output logic [2*NUM_SRC-1:0] mode_o,
  output logic                 rd_clr_o
);
  localparam int MODE_REGS = (2 * NUM_SRC + DATA_W - 1) / DATA_W;

  logic               cfg_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [DATA_W-1:0]  mode_q [MODE_REGS];
  logic [MODE_REGS*DATA_W-1:0] mode_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= 1'b0;
      mask_q <= '1;
      for (int j = 0; j < MODE_REGS; j++) mode_q[j] <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CFG)  cfg_q  <= wr_data_i[0];
      if (addr_i == A_MASK) mask_q <= wr_data_i[NUM_SRC-1:0];
      for (int j = 0; j < MODE_REGS; j++)
        if (addr_i == A_MODE0 + ADDR_W'(j)) mode_q[j] <= wr_data_i;
    end
  end

  always_comb begin
    for (int j = 0; j < MODE_REGS; j++)
      for (int b = 0; b < DATA_W; b++)
        mode_all[j*DATA_W+b] = mode_q[j][b];
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_CFG)  rd_data_o = DATA_W'(cfg_q);
    if (addr_i == A_MASK) rd_data_o = DATA_W'(mask_q);
    if (addr_i == A_STAT) rd_data_o = DATA_W'(status_i);
    for (int j = 0; j < MODE_REGS; j++)
      if (addr_i == A_MODE0 + ADDR_W'(j)) rd_data_o = mode_q[j];
  end

  assign cfg_od_o = cfg_q;
  assign mask_o   = mask_q;
  assign mode_o   = mode_all[2*NUM_SRC-1:0];
  assign rd_clr_o = rd_en_i && (addr_i == A_STAT);
endmodule

// File: rtl/irq_aggr_ctrl.sv
module irq_aggr_ctrl
  import irq_aggr_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  parameter int OVF_IDX = 6,
  parameter int UNF_IDX = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o,
  output logic               irq_oe,
  output logic               ovfl_o,
  output logic               ovfl_oe
);
  logic                 cfg_od_w;
  logic                 rd_clr_w;
  logic                 pend_w;
  logic [NUM_SRC-1:0]   mask_w;
  logic [2*NUM_SRC-1:0] mode_w;
  logic [NUM_SRC-1:0]   sync_w, edge_w, sticky_w, status_w, lvl_w;

  irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .status_i  (status_w),
    .rd_data_o (rd_data_o),
    .cfg_od_o  (cfg_od_w),
    .mask_o    (mask_w),
    .mode_o    (mode_w),
    .rd_clr_o  (rd_clr_w)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    trig_e mode_i_w;
    assign mode_i_w = trig_e'(mode_w[2*i +: 2]);
    assign lvl_w[i] = trig_is_level(mode_i_w);
    irq_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[i]),
      .mode_i   (mode_i_w),
      .clr_i    (rd_clr_w),
      .sync_o   (sync_w[i]),
      .edge_o   (edge_w[i]),
      .sticky_o (sticky_w[i]),
      .stat_o   (status_w[i])
    );
  end

  assign pend_w  = |(status_w & ~mask_w);
  assign irq_o   = cfg_od_w ? 1'b0   : pend_w;
  assign irq_oe  = cfg_od_w ? pend_w : 1'b1;
  assign ovfl_o  = 1'b0;
  assign ovfl_oe = status_w[OVF_IDX] | status_w[UNF_IDX];
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int NUM_SRC = 8,
  parameter int OVF_IDX = 6,
  parameter int UNF_IDX = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_od_w,
  input logic               rd_clr_w,
  input logic [NUM_SRC-1:0] mask_w,
  input logic [NUM_SRC-1:0] status_w,
  input logic [NUM_SRC-1:0] sticky_w,
  input logic [NUM_SRC-1:0] edge_w,
  input logic [NUM_SRC-1:0] lvl_w,
  input logic               irq_o,
  input logic               irq_oe,
  input logic               ovfl_o,
  input logic               ovfl_oe
);
  // R2
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_w) |=> ((sticky_w & $past(edge_w)) == $past(edge_w)));
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_w |=> ((sticky_w & ~$past(edge_w)) == '0));
  // R4
  lvl_nosticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lvl_w) |=> ((sticky_w & $past(lvl_w)) == '0));
  // R6
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & ~mask_w) == '0) |-> !(cfg_od_w ? irq_oe : irq_o));
  // R7
  pp_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_od_w |-> irq_oe);
  // R8
  od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_od_w |-> !irq_o);
  // R9
  ovfl_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovfl_oe |-> (status_w[OVF_IDX] || status_w[UNF_IDX]));
  // R9
  ovfl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovfl_o);
endmodule

bind irq_aggr_ctrl irq_aggr_chk #(
  .NUM_SRC(NUM_SRC), .OVF_IDX(OVF_IDX), .UNF_IDX(UNF_IDX)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_od_w (cfg_od_w),
  .rd_clr_w (rd_clr_w),
  .mask_w   (mask_w),
  .status_w (status_w),
  .sticky_w (sticky_w),
  .edge_w   (edge_w),
  .lvl_w    (lvl_w),
  .irq_o    (irq_o),
  .irq_oe   (irq_oe),
  .ovfl_o   (ovfl_o),
  .ovfl_oe  (ovfl_oe)
);

// File: tb/irq_aggr_ctrl_tb.sv
module irq_aggr_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_o, irq_oe, ovfl_o, ovfl_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_aggr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .irq_o(irq_o), .irq_oe(irq_oe), .ovfl_o(ovfl_o), .ovfl_oe(ovfl_oe)
  );

  // bench-side restatement of the mode code meaning
  function automatic string mode_name(logic [1:0] m);
    return (m == 2'b01) ? "rise" : (m == 2'b10) ? "fall" : "level";
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_en && rst_n) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        failures++;
        $display("FAIL %s read addr %h: got %h expected %h", t, addr, rd_data, e);
      end
    end
  end

  task automatic pins(logic eo, logic eoe, logic fo, logic foe, string tag);
    @(negedge clk);
    checks++;
    if ({irq_o, irq_oe, ovfl_o, ovfl_oe} !== {eo, eoe, fo, foe}) begin
      failures++;
      $display("FAIL %s pins irq_o/irq_oe/ovfl_o/ovfl_oe: got %b%b%b%b expected %b%b%b%b",
               tag, irq_o, irq_oe, ovfl_o, ovfl_oe, eo, eoe, fo, foe);
    end
    tick(1);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    pins(1'b0, 1'b1, 1'b0, 1'b0, "R1");
    rd(4'hD, 8'h00, "R1");
    rd(4'h1, 8'hFF, "R1");
    rd(4'h0, 8'h00, "R1");
    rd(4'h4, 8'h00, "R1");
    // R10 mode map: src0 rise, src1 fall, src2 level, src3 code 11 (level)
    wr(4'h4, 8'hC9);
    rd(4'h4, 8'hC9, "R10");
    $display("src0 %s src1 %s", mode_name(2'b01), mode_name(2'b10));
    // src4 rise, src5 rise, src6 level, src7 level
    wr(4'h5, 8'h05);
    rd(4'h5, 8'h05, "R10");
    rd(4'h3, 8'h00, "R10");
    // R2 rising pulse on src0, masked
    src[0] = 1'b1; tick(3);
    src[0] = 1'b0; tick(3);
    pins(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    wr(4'h1, 8'hFE);
    pins(1'b1, 1'b1, 1'b0, 1'b0, "R7");
    rd(4'hD, 8'h01, "R2");
    rd(4'hD, 8'h00, "R5");
    pins(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    // R3 falling mode on src1
    src[1] = 1'b1; tick(3);
    rd(4'hD, 8'h00, "R3");
    src[1] = 1'b0; tick(3);
    rd(4'hD, 8'h02, "R3");
    rd(4'hD, 8'h00, "R3");
    // R4 level modes
    src[2] = 1'b1; tick(3);
    rd(4'hD, 8'h04, "R4");
    rd(4'hD, 8'h04, "R4");
    src[3] = 1'b1; tick(3);
    rd(4'hD, 8'h0C, "R4");
    src[2] = 1'b0; src[3] = 1'b0; tick(3);
    rd(4'hD, 8'h00, "R4");
    // R8 open-drain
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h01, "R10");
    wr(4'h1, 8'h00);
    src[2] = 1'b1; tick(3);
    pins(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    src[2] = 1'b0; tick(3);
    pins(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R9 overflow ignores mask
    wr(4'h0, 8'h00);
    wr(4'h1, 8'hFF);
    src[6] = 1'b1; tick(3);
    pins(1'b0, 1'b1, 1'b0, 1'b1, "R9");
    src[6] = 1'b0; tick(3);
    pins(1'b0, 1'b1, 1'b0, 1'b0, "R9");
    src[7] = 1'b1; tick(3);
    pins(1'b0, 1'b1, 1'b0, 1'b1, "R9");
    src[7] = 1'b0; tick(3);
    // R5 read in the same cycle as a qualified rising edge on src4
    src[4] = 1'b1; tick(2);
    rd(4'hD, 8'h00, "R5");
    rd(4'hD, 8'h10, "R5");
    rd(4'hD, 8'h00, "R5");
    src[4] = 1'b0; tick(3);
    // R10 status is read-only
    wr(4'hD, 8'hFF);
    rd(4'hD, 8'h00, "R10");
    tick(2);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule